// File: doc/BRIEF.md
# Vertical Blanking Ancillary Line Passthrough Gate

This block sits in front of the range clipper of a 4:2:2 video output pipeline. For each incoming byte it decides whether the current line is a line that carries ancillary data in the vertical blanking interval. On such a line, with the raw-data mode enabled, the byte is forwarded bit for bit and a route select tells the downstream clipper to leave it alone. On every other line the byte goes to the normal processing path. An external timing generator supplies the line number, which counts from 1 across both fields of a frame. A standard select chooses between the 525-line and 625-line window sets.

The data byte, the active flag and the route select all leave through one register stage, so they stay aligned with one cycle of latency. The mode enable and the standard select can change at any time. The gate samples them only on the first byte of a new line, which it detects as a change in the line number. A line therefore never mixes bytes from both paths.

Top module: `vbi_gate`

## Requirements
- R1: With the 525-line standard (std_625 = 0) and the mode enabled, lines 10 to 20 inclusive give vbi_active = 1, and lines 9 and 21 give 0.
- R2: With the 525-line standard and the mode enabled, lines 272 to 283 inclusive give vbi_active = 1, and lines 271 and 284 give 0. No line outside R1 and R2 is active in this standard.
- R3: With the 625-line standard (std_625 = 1) and the mode enabled, lines 6 to 22 and lines 318 to 335 inclusive give vbi_active = 1, and every other line gives 0.
- R4: With the enable held low, vbi_active is 0 on every line number in both standards.
- R5: dout equals the din presented one clock earlier, for every byte value including 0x00 and 0xFF, on active and inactive lines alike.
- R6: vbi_active describes the byte on dout in the same cycle, one cycle after din. route_normal is always the inverse of vbi_active (1 = send to the normal clipping path).
- R7: A line boundary is any cycle in which line_num differs from its value in the previous cycle. vbi_en and std_625 are sampled only at a boundary. Changes between boundaries take effect from the next boundary.
- R8: While rst_n is low, dout = 0, vbi_active = 0 and route_normal = 1. The first cycle after reset counts as a line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbi_en | input | 1 | Raw ancillary-data mode enable |
| std_625 | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| line_num | input | LW (10) | Current line number from the timing generator, 1-based across the frame |
| din | input | DW (8) | Incoming video byte |
| dout | output | DW (8) | Registered video byte |
| vbi_active | output | 1 | Registered flag: dout belongs to an ancillary line in raw mode |
| route_normal | output | 1 | Route select toward the clipper: 1 = normal path, 0 = bypass |

## Verification
Full sweeps of every line number in each standard with the mode enabled separate the two standards' windows and catch off-by-one edges at all window limits. A sweep with the mode disabled separates the enable gating from the window decode. Directed mid-line toggles of the enable and the standard tell sampling at the line boundary apart from sampling on every byte. Random runs then mix line lengths, toggle timing and byte values that include 0x00 and 0xFF, which tells true passthrough apart from any range limiting.

// File: rtl/vbi_gate.sv
module vbi_gate #(
  parameter int DW = 8,
  parameter int LW = 10,
  parameter int N1_LO = 10,
  parameter int N1_HI = 20,
  parameter int N2_LO = 272,
  parameter int N2_HI = 283,
  parameter int P1_LO = 6,
  parameter int P1_HI = 22,
  parameter int P2_LO = 318,
  parameter int P2_HI = 335
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vbi_en,
  input  logic          std_625,
  input  logic [LW-1:0] line_num,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vbi_active,
  output logic          route_normal
);

  logic [LW-1:0] line_prev;
  logic          en_q, std_q;

  wire new_line = (line_num != line_prev);
  wire en_eff   = new_line ? vbi_en  : en_q;
  wire std_eff  = new_line ? std_625 : std_q;

  function automatic logic in_rng(input logic [LW-1:0] l, input int lo, input int hi);
    return (l >= LW'(lo)) && (l <= LW'(hi));
  endfunction

  wire win_525 = in_rng(line_num, N1_LO, N1_HI) | in_rng(line_num, N2_LO, N2_HI);
  wire win_625 = in_rng(line_num, P1_LO, P1_HI) | in_rng(line_num, P2_LO, P2_HI);
  wire hit     = en_eff & (std_eff ? win_625 : win_525);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev  <= '0;
      en_q       <= 1'b0;
      std_q      <= 1'b0;
      dout       <= '0;
      vbi_active <= 1'b0;
    end else begin
      line_prev  <= line_num;
      en_q       <= en_eff;
      std_q      <= std_eff;
      dout       <= din;
      vbi_active <= hit;
    end
  end

  assign route_normal = ~vbi_active;

endmodule

// File: rtl/vbi_gate_chk.sv
module vbi_gate_chk #(
  parameter int DW = 8,
  parameter int LW = 10,
  parameter int N1_LO = 10,
  parameter int N1_HI = 20,
  parameter int N2_LO = 272,
  parameter int N2_HI = 283,
  parameter int P1_LO = 6,
  parameter int P1_HI = 22,
  parameter int P2_LO = 318,
  parameter int P2_HI = 335
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] line_num,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic          vbi_active,
  input logic          route_normal
);

  logic [1:0]    warm;
  logic [LW-1:0] seen_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm      <= '0;
      seen_line <= '0;
    end else begin
      if (warm != 2'd2) warm <= warm + 2'd1;
      seen_line <= line_num;
    end
  end

  function automatic logic any_win(input logic [LW-1:0] l);
    return ((l >= LW'(N1_LO)) && (l <= LW'(N1_HI))) ||
           ((l >= LW'(N2_LO)) && (l <= LW'(N2_HI))) ||
           ((l >= LW'(P1_LO)) && (l <= LW'(P1_HI))) ||
           ((l >= LW'(P2_LO)) && (l <= LW'(P2_HI)));
  endfunction

  // R6
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_normal != vbi_active);

  // R5
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0) |=> dout == $past(din));

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && line_num == $past(line_num)) |=> vbi_active == $past(vbi_active));

  // R1 R2 R3
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && vbi_active) |-> any_win(seen_line));

endmodule

bind vbi_gate vbi_gate_chk #(
  .DW(DW), .LW(LW),
  .N1_LO(N1_LO), .N1_HI(N1_HI), .N2_LO(N2_LO), .N2_HI(N2_HI),
  .P1_LO(P1_LO), .P1_HI(P1_HI), .P2_LO(P2_LO), .P2_HI(P2_HI)
) i_chk (
  .clk(clk), .rst_n(rst_n), .line_num(line_num), .din(din),
  .dout(dout), .vbi_active(vbi_active), .route_normal(route_normal)
);

// File: tb/test_vbi_gate.sv
`timescale 1ns/1ps
module test_vbi_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vbi_en = 1'b0;
  logic       std_625 = 1'b0;
  logic [9:0] line_num = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       vbi_active, route_normal;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [9:0] m_prev;
  logic       m_en, m_std;

  always #2 clk = ~clk;

  vbi_gate i_vbi_gate (
    .clk(clk), .rst_n(rst_n), .vbi_en(vbi_en), .std_625(std_625),
    .line_num(line_num), .din(din), .dout(dout),
    .vbi_active(vbi_active), .route_normal(route_normal)
  );

  function automatic bit exp_win(input int l, input bit s625);
    if (s625) return (l >= 6 && l <= 22) || (l >= 318 && l <= 335);
    return (l >= 10 && l <= 20) || (l >= 272 && l <= 283);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (line %0d)", tag, act, exp, line_num);
    end
  endtask

  task automatic step(input string tag, input int l, input bit en, input bit s, input logic [7:0] d);
    bit nl, e, st, ea;
    line_num = l[9:0]; vbi_en = en; std_625 = s; din = d;
    nl = (l[9:0] != m_prev);
    e  = nl ? en : m_en;
    st = nl ? s : m_std;
    ea = e & exp_win(l, st);
    m_prev = l[9:0]; m_en = e; m_std = st;
    @(posedge clk); #1;
    chk("R5 data", int'(dout), int'(d));
    chk(tag, int'(vbi_active), int'(ea));
    chk("R6 route", int'(route_normal), int'(!ea));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd4242;
    void'($urandom(seed));
    line_num = 10'd15; vbi_en = 1'b1; din = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 dout", int'(dout), 0);
    chk("R8 active", int'(vbi_active), 0);
    chk("R8 route", int'(route_normal), 1);
    @(negedge clk);
    rst_n = 1'b1;
    m_prev = '0; m_en = 1'b0; m_std = 1'b0;

    for (int l = 1; l <= 600; l++)
      for (int b = 0; b < 2; b++)
        step("R1/R2 525 sweep", l, 1'b1, 1'b0, 8'($urandom));
    for (int l = 1; l <= 640; l++)
      for (int b = 0; b < 2; b++)
        step("R3 625 sweep", l, 1'b1, 1'b1, 8'($urandom));
    for (int l = 1; l <= 400; l++) begin
      step("R4 disabled", l, 1'b0, l[0], 8'hFF);
      step("R4 disabled", l, 1'b0, l[0], 8'h00);
    end

    step("R7 enable", 15, 1'b1, 1'b0, 8'h00);
    step("R7 enable", 15, 1'b0, 1'b0, 8'hFF);
    step("R7 enable", 15, 1'b0, 1'b0, 8'h01);
    step("R7 enable", 16, 1'b0, 1'b0, 8'hFE);
    step("R7 std", 21, 1'b1, 1'b0, 8'h10);
    step("R7 std", 21, 1'b1, 1'b1, 8'hEB);
    step("R7 std", 22, 1'b1, 1'b1, 8'hF0);
    step("R7 std", 22, 1'b1, 1'b0, 8'h00);
    step("R7 std", 272, 1'b1, 1'b1, 8'hFF);

    for (int n = 0; n < 800; n++) begin
      int l, len;
      bit en, s;
      logic [7:0] d;
      case ($urandom % 4)
        0: l = 4 + int'($urandom % 22);
        1: l = 268 + int'($urandom % 20);
        2: l = 314 + int'($urandom % 26);
        default: l = 1 + int'($urandom % 700);
      endcase
      en  = ($urandom % 4) != 0;
      s   = $urandom % 2;
      len = 1 + int'($urandom % 5);
      for (int b = 0; b < len; b++) begin
        if ($urandom % 4 == 0) en = ~en;
        if ($urandom % 5 == 0) s = ~s;
        case ($urandom % 4)
          0: d = 8'h00;
          1: d = 8'hFF;
          default: d = 8'($urandom);
        endcase
        step("R7 random", l, en, s, d);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule